// File: doc/BRIEF.md
# Weighted Early Drop Decision for an Egress Port

This block decides, for each packet arriving at one egress port, whether the packet is admitted or discarded before it is queued. The port has six managed priority queues, P2 up to P7, and each reports its current byte occupancy. From these occupancies the block forms a congestion figure N. In delay-bound scheduling the deeper classes weigh more heavily in N. In weighted-fair scheduling N is the plain total.

N is graded against three fixed congestion levels. A request carries the target queue number and a one-bit drop precedence. Within the level that N reaches, the block applies a programmable drop percentage that depends on that precedence. At the lowest level, the target queue's own occupancy must also be above its own programmable threshold. A free-running pseudo-random source turns each percentage into a drop or admit verdict.

The verdict is registered and appears one cycle after the request strobe. Queues P0 and P1 are outside early-drop control.

Top module: `wred_early_drop`

## Requirements
- R1: With `mode_dly_i` = 1 (delay-bound), N = 16·C7 + 16·C6 + 8·C5 + 4·C4 + 2·C3 + C2, where Ck is the byte count of queue Pk. Slice i of `qbytes_i` carries queue P(i+2).
- R2: With `mode_dly_i` = 0 (weighted-fair), N = C2 + C3 + C4 + C5 + C6 + C7.
- R3: A request to a queue P2..P7 is dropped whenever N > 327680 bytes (320 KB), whatever its precedence and whatever the percentages.
- R4: When 286720 < N ≤ 327680 (above 280 KB), a high-drop packet (`req_high_i` = 1) is dropped if the random roll r < `pct_y_i`. A low-drop packet is dropped if r < `pct_z_i`.
- R5: When 245760 < N ≤ 286720, and the target queue's count is strictly above its threshold (the slice of `qthr_i` with the same index), a high-drop packet is dropped if r < `pct_x_i`. A low-drop packet is never dropped.
- R6: A request to P2..P7 is admitted when N ≤ 245760. It is also admitted when N is in the lowest level but the target queue's count is not above its threshold.
- R7: Requests to queue P0 or P1 (`req_queue_i` < 2) are always admitted.
- R8: `vld_o` is high exactly one cycle after a cycle with `req_i` high. `drop_o` is high only together with `vld_o`. Both outputs are 0 during reset and in cycles after no request.
- R9: The random source is a 16-bit Galois LFSR. Reset loads it with 16'hACE1, and it advances on every clock out of reset as s' = {0, s[15:1]} ^ (s[0] ? 16'hB400 : 0). The roll is r = (s·100) >> 16, in the range 0..99, taken from the state present in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dly_i | input | 1 | 1 = delay-bound weighting, 0 = weighted-fair sum |
| qbytes_i | input | 6*CNT_W | Byte counts; slice i is queue P(i+2) |
| qthr_i | input | 6*CNT_W | Per-queue lowest-level thresholds, same slicing |
| pct_x_i | input | 7 | Lowest-level drop percent, high-drop packets |
| pct_y_i | input | 7 | Middle-level drop percent, high-drop packets |
| pct_z_i | input | 7 | Middle-level drop percent, low-drop packets |
| req_i | input | 1 | Request strobe |
| req_queue_i | input | 3 | Target queue number 0..7 |
| req_high_i | input | 1 | 1 = high-drop precedence, 0 = low-drop |
| vld_o | output | 1 | Verdict valid |
| drop_o | output | 1 | 1 = discard, 0 = admit |

## Verification
On every cycle, the assertions check the verdict timing and pairing. They also check that P0/P1 are never dropped, that traffic above the top level is always dropped, and that low-drop traffic below the middle level is never dropped. They watch the LFSR range as well. The exact weighting of N in each mode, the boundaries at exactly 240/280/320 KB, the per-queue threshold test and the percentage comparison against the roll can only be shown by the bench. The bench drives directed and random occupancy patterns against its own model.

// File: rtl/wred_pkg.sv
package wred_pkg;

    localparam int unsigned NQ      = 6;
    localparam int unsigned KBYTE   = 1024;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;

    typedef enum logic {
        SCHED_WFQ   = 1'b0,
        SCHED_DELAY = 1'b1
    } sched_e;

    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_ONE   = 2'd1,
        LVL_TWO   = 2'd2,
        LVL_THREE = 2'd3
    } level_e;

    typedef struct packed {
        logic [2:0] queue;
        logic       high;
    } pkt_req_t;

    // weight of queue slot idx (slot 0 = P2) under delay-bound weighting
    function automatic logic [4:0] delay_weight(int unsigned idx);
        case (idx)
            0:       return 5'd1;
            1:       return 5'd2;
            2:       return 5'd4;
            3:       return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/wred_sum.sv
module wred_sum
    import wred_pkg::*;
#(
    parameter int unsigned CNT_W = 18,
    parameter int unsigned N_W   = CNT_W + 6
) (
    input  sched_e                 mode,
    input  logic [NQ*CNT_W-1:0]    qbytes,
    output logic [N_W-1:0]         nsum
);
    logic [N_W-1:0] term [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_term
        localparam logic [N_W-1:0] WGT = N_W'(delay_weight(g));
        logic [N_W-1:0] cnt_ext;
        assign cnt_ext = N_W'(qbytes[g*CNT_W +: CNT_W]);
        assign term[g] = (mode == SCHED_DELAY) ? cnt_ext * WGT : cnt_ext;
    end

    always_comb begin
        nsum = '0;
        for (int i = 0; i < NQ; i++) begin
            nsum = nsum + term[i];
        end
    end
endmodule

// File: rtl/wred_level.sv
module wred_level
    import wred_pkg::*;
#(
    parameter int unsigned N_W    = 24,
    parameter int unsigned LVL1_B = 240 * KBYTE,
    parameter int unsigned LVL2_B = 280 * KBYTE,
    parameter int unsigned LVL3_B = 320 * KBYTE
) (
    input  logic [N_W-1:0] nsum,
    output level_e         level
);
    localparam logic [N_W-1:0] T1 = N_W'(LVL1_B);
    localparam logic [N_W-1:0] T2 = N_W'(LVL2_B);
    localparam logic [N_W-1:0] T3 = N_W'(LVL3_B);

    always_comb begin
        if (nsum > T3)      level = LVL_THREE;
        else if (nsum > T2) level = LVL_TWO;
        else if (nsum > T1) level = LVL_ONE;
        else                level = LVL_NONE;
    end
endmodule

// File: rtl/wred_lfsr.sv
module wred_lfsr
    import wred_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] state,
    output logic [6:0]  roll
);
    logic [22:0] prod;

    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_SEED;
        else     state <= {1'b0, state[15:1]} ^ (state[0] ? LFSR_TAPS : 16'h0000);
    end

    assign prod = 23'(state) * 23'd100;
    assign roll = prod[22:16];
endmodule

// File: rtl/wred_early_drop.sv
module wred_early_drop
    import wred_pkg::*;
#(
    parameter int unsigned CNT_W  = 18,
    parameter int unsigned LVL1_B = 240 * KBYTE,
    parameter int unsigned LVL2_B = 280 * KBYTE,
    parameter int unsigned LVL3_B = 320 * KBYTE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_dly_i,
    input  logic [6*CNT_W-1:0]   qbytes_i,
    input  logic [6*CNT_W-1:0]   qthr_i,
    input  logic [6:0]           pct_x_i,
    input  logic [6:0]           pct_y_i,
    input  logic [6:0]           pct_z_i,
    input  logic                 req_i,
    input  logic [2:0]           req_queue_i,
    input  logic                 req_high_i,
    output logic                 vld_o,
    output logic                 drop_o
);
    localparam int unsigned N_W = CNT_W + 6;

    sched_e          mode;
    pkt_req_t        pkt;
    logic [N_W-1:0]  nsum;
    level_e          level;
    logic [15:0]     lfsr_state;
    logic [6:0]      roll;
    logic            managed;
    logic [2:0]      slot;
    logic [CNT_W-1:0] own_cnt;
    logic [CNT_W-1:0] own_thr;
    logic            own_over;
    logic            drop_d;

    assign mode = mode_dly_i ? SCHED_DELAY : SCHED_WFQ;
    assign pkt  = '{queue: req_queue_i, high: req_high_i};

    wred_sum #(.CNT_W(CNT_W), .N_W(N_W)) u_sum (
        .mode   (mode),
        .qbytes (qbytes_i),
        .nsum   (nsum)
    );

    wred_level #(.N_W(N_W), .LVL1_B(LVL1_B), .LVL2_B(LVL2_B), .LVL3_B(LVL3_B)) u_level (
        .nsum  (nsum),
        .level (level)
    );

    wred_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_state),
        .roll  (roll)
    );

    // own-queue threshold test for the lowest level
    assign managed  = (pkt.queue >= 3'd2);
    assign slot     = managed ? (pkt.queue - 3'd2) : 3'd0;
    assign own_cnt  = qbytes_i[slot*CNT_W +: CNT_W];
    assign own_thr  = qthr_i[slot*CNT_W +: CNT_W];
    assign own_over = own_cnt > own_thr;

    always_comb begin
        drop_d = 1'b0;
        if (managed) begin
            unique case (level)
                LVL_THREE: drop_d = 1'b1;
                LVL_TWO:   drop_d = pkt.high ? (roll < pct_y_i) : (roll < pct_z_i);
                LVL_ONE:   drop_d = own_over && pkt.high && (roll < pct_x_i);
                default:   drop_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            drop_o <= 1'b0;
        end else begin
            vld_o  <= req_i;
            drop_o <= req_i & drop_d;
        end
    end
endmodule

// File: rtl/wred_checker.sv
module wred_checker #(
    parameter int unsigned N_W    = 24,
    parameter int unsigned LVL2_B = 280 * 1024,
    parameter int unsigned LVL3_B = 320 * 1024
) (
    input logic           clk,
    input logic           rst,
    input logic           req_i,
    input logic [2:0]     req_queue_i,
    input logic           req_high_i,
    input logic [N_W-1:0] nsum,
    input logic [15:0]    lfsr_state,
    input logic [6:0]     roll,
    input logic           vld_o,
    input logic           drop_o
);
    localparam logic [N_W-1:0] T2 = N_W'(LVL2_B);
    localparam logic [N_W-1:0] T3 = N_W'(LVL3_B);

    assert_valid_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
        req_i |=> vld_o);
    assert_no_valid_without_req_R8: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !vld_o);
    assert_drop_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        drop_o |-> vld_o);
    assert_low_queues_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_i && req_queue_i < 3'd2) |=> !drop_o);
    assert_top_level_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i && req_queue_i >= 3'd2 && nsum > T3) |=> drop_o);
    assert_low_prec_safe_R5: assert property (@(posedge clk) disable iff (rst)
        (req_i && req_queue_i >= 3'd2 && !req_high_i && nsum <= T2) |=> !drop_o);
    assert_lfsr_alive_R9: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 16'h0000);
    assert_roll_range_R9: assert property (@(posedge clk) disable iff (rst)
        roll < 7'd100);
endmodule

bind wred_early_drop wred_checker #(
    .N_W    (N_W),
    .LVL2_B (LVL2_B),
    .LVL3_B (LVL3_B)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .req_queue_i (req_queue_i),
    .req_high_i  (req_high_i),
    .nsum        (nsum),
    .lfsr_state  (lfsr_state),
    .roll        (roll),
    .vld_o       (vld_o),
    .drop_o      (drop_o)
);

// File: tb/wred_early_drop_test.sv
`timescale 1ns/1ps
module wred_early_drop_test;
    localparam int CNT_W = 18;
    localparam longint L1 = 240 * 1024;
    localparam longint L2 = 280 * 1024;
    localparam longint L3 = 320 * 1024;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst;
    logic               mode_dly_i;
    logic [6*CNT_W-1:0] qbytes_i;
    logic [6*CNT_W-1:0] qthr_i;
    logic [6:0]         pct_x_i, pct_y_i, pct_z_i;
    logic               req_i;
    logic [2:0]         req_queue_i;
    logic               req_high_i;
    logic               vld_o, drop_o;

    int unsigned cnt [6];
    int unsigned thr [6];

    always_comb begin
        for (int i = 0; i < 6; i++) begin
            qbytes_i[i*CNT_W +: CNT_W] = CNT_W'(cnt[i]);
            qthr_i[i*CNT_W +: CNT_W]   = CNT_W'(thr[i]);
        end
    end

    wred_early_drop #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .mode_dly_i(mode_dly_i),
        .qbytes_i(qbytes_i), .qthr_i(qthr_i),
        .pct_x_i(pct_x_i), .pct_y_i(pct_y_i), .pct_z_i(pct_z_i),
        .req_i(req_i), .req_queue_i(req_queue_i), .req_high_i(req_high_i),
        .vld_o(vld_o), .drop_o(drop_o)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s vld/drop actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    logic [15:0] m_lfsr;
    bit          e_v, e_d;
    string       e_tag;

    function automatic void evaluate(output bit d, output string t);
        longint n;
        int     r;
        int     s;
        if (mode_dly_i)
            n = 16*cnt[5] + 16*cnt[4] + 8*cnt[3] + 4*cnt[2] + 2*cnt[1] + cnt[0];
        else
            n = cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4] + cnt[5];
        r = (int'(m_lfsr) * 100) >>> 16;
        d = 0;
        if (!req_i) t = "R8";
        else if (req_queue_i < 2) t = "R7";
        else begin
            s = int'(req_queue_i) - 2;
            if (n > L3) begin d = 1; t = "R3"; end
            else if (n > L2) begin
                d = req_high_i ? (r < int'(pct_y_i)) : (r < int'(pct_z_i));
                t = "R4 R9";
            end else if (n > L1 && cnt[s] > thr[s]) begin
                d = req_high_i && (r < int'(pct_x_i));
                t = "R5 R9";
            end else t = "R6";
            t = {t, mode_dly_i ? " R1" : " R2"};
        end
    endfunction

    always @(posedge clk) begin
        bit    d;
        string t;
        if (rst) begin
            m_lfsr <= 16'hACE1;
            e_v    <= 0;
            e_d    <= 0;
            e_tag  <= "R8";
        end else begin
            evaluate(d, t);
            e_v    <= req_i;
            e_d    <= req_i && d;
            e_tag  <= t;
            m_lfsr <= {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
        end
    end

    always @(negedge clk) begin
        if (rst) check("R8 reset", {vld_o, drop_o}, 2'b00);
        else     check(e_tag, {vld_o, drop_o}, {e_v, e_d});
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_q();
        for (int i = 0; i < 6; i++) begin cnt[i] = 0; thr[i] = 0; end
    endtask

    task automatic send(int q, bit hi);
        req_i = 1; req_queue_i = 3'(q); req_high_i = hi;
        step();
        req_i = 0;
    endtask

    initial begin
        rst = 1; mode_dly_i = 1; req_i = 0; req_queue_i = 0; req_high_i = 0;
        pct_x_i = 0; pct_y_i = 0; pct_z_i = 0;
        clear_q();
        repeat (3) step();
        rst = 0;
        step();

        // R1 lowest level via delay weighting: 16*15361 just above 240 KB
        cnt[5] = 15361; pct_x_i = 100;
        send(7, 1); send(7, 0);
        thr[5] = 20000; send(7, 1);
        thr[5] = 0;
        // R2 same counts, plain sum far below
        mode_dly_i = 0; send(7, 1);
        // R6/R5 boundary exactly at 240 KB
        clear_q(); cnt[0] = 245760; send(2, 1);
        cnt[0] = 245761; send(2, 1); send(3, 1);
        // R4 middle level
        clear_q(); cnt[0] = 200000; cnt[1] = 86721;
        pct_y_i = 100; pct_z_i = 0; send(2, 1); send(2, 0);
        pct_y_i = 0; pct_z_i = 100; send(4, 1); send(4, 0);
        // R3 top level, boundary then above
        clear_q(); cnt[0] = 200000; cnt[1] = 127680;
        pct_x_i = 0; pct_y_i = 0; pct_z_i = 0; send(5, 1);
        cnt[1] = 127681; send(5, 1); send(6, 0);
        // R7 queues P0 and P1 under top-level congestion
        send(0, 1); send(1, 0);
        // R9 probabilistic middle level
        clear_q(); cnt[0] = 200000; cnt[1] = 90000;
        pct_y_i = 50; pct_z_i = 25;
        for (int k = 0; k < 200; k++) send(2 + (k % 6), k[0]);
        // random mixes
        for (int k = 0; k < 4000; k++) begin
            mode_dly_i = 1'($urandom_range(0, 1));
            for (int i = 0; i < 6; i++) begin
                cnt[i] = mode_dly_i ? $urandom_range(4000, 8600) : $urandom_range(30000, 66000);
                thr[i] = mode_dly_i ? $urandom_range(3000, 9000) : $urandom_range(25000, 70000);
            end
            pct_x_i = 7'($urandom_range(0, 100));
            pct_y_i = 7'($urandom_range(0, 100));
            pct_z_i = 7'($urandom_range(0, 100));
            req_i       = ($urandom_range(0, 3) != 0);
            req_queue_i = 3'($urandom_range(0, 7));
            req_high_i  = 1'($urandom_range(0, 1));
            step();
        end
        req_i = 0;
        step(); step();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R8 watchdog actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule